// File: doc/BRIEF.md
# CPU Processing State Controller

This block decides which processing state a small CPU core occupies at any moment. It takes an active-low reset pin, an active-low hardware standby pin, an external bus request, an interrupt request, trap and trace requests, a strobe that reports an executed sleep instruction, and a handshake that reports a finished vector fetch. From these it drives a one-hot state indication, a bus grant, a halt signal for the core, an interrupt mask, and a vector fetch request with its vector number.

There are six states: reset, exception handling, program execution, bus released, program stop and hardware standby. When several conditions arrive in the same cycle, a fixed priority picks one. Standby beats reset. Reset beats a bus request. A bus request beats the exception sources. The exception sources beat sleep. Every input is sampled on the rising clock edge, and the outputs follow from the registered state one edge later.

Top module: `procStateCtl`

## Requirements
- R1: `stateOh` has exactly one bit set after the first clock edge. The bit positions are: bit 0 reset, bit 1 exception handling, bit 2 program execution, bit 3 bus released, bit 4 program stop, bit 5 hardware standby.
- R2: When `standbyN` is sampled low, the next state is hardware standby. This holds from every state and regardless of `resetN`.
- R3: Hardware standby is left only at an edge where both `standbyN` and `resetN` are sampled high. The next state is then reset, followed by reset exception handling at the next edge if `resetN` stays high.
- R4: When `resetN` is sampled low outside standby, the next state is reset. `intMask` is high in the reset, exception-handling and standby states and low in all others.
- R5: In the reset state, the first edge that samples `resetN` high moves to exception handling with vector number `VEC_RESET` (default 0). While `resetN` stays low, the controller remains in reset.
- R6: In exception handling, `vecReq` is high and `vecNum` holds the source's vector. The edge that samples `vecDone` high moves to program execution.
- R7: In program execution the priority is `busReq`, then `trapReq` (vector `VEC_TRAP`, default 8), then `traceReq` (vector `VEC_TRACE`, default 5), then `irqReq` (vector `VEC_IRQ`, default 16), then `sleepDone`.
- R8: `busReq` sampled high in program execution moves to bus released, and `busGrant` rises at that same edge. `busGrant` is never high outside bus released.
- R9: In bus released, `busGrant` falls at the first edge that samples `busReq` low. Program execution resumes one edge later, provided `busReq` is still low.
- R10: `sleepDone` in program execution moves to program stop. In program stop, only `irqReq` (into exception handling with `VEC_IRQ`), reset or standby cause a change. Trap, trace, bus request and sleep are ignored there.
- R11: `cpuHalt` is high in the reset, bus released, program stop and standby states and low in program execution and exception handling.
- R12: In exception handling, bus, trap, trace, interrupt and sleep requests are ignored. Only `vecDone`, reset or standby end the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| resetN | input | 1 | Reset pin, active low, sampled synchronously |
| standbyN | input | 1 | Hardware standby pin, active low |
| busReq | input | 1 | Bus request from another master |
| irqReq | input | 1 | Interrupt request |
| traceReq | input | 1 | Trace exception request |
| trapReq | input | 1 | Trap exception request |
| sleepDone | input | 1 | Strobe: a sleep instruction was executed |
| vecDone | input | 1 | Vector fetch and branch finished |
| stateOh | output | 6 | One-hot processing state |
| busGrant | output | 1 | Bus handed to the other master |
| cpuHalt | output | 1 | Core must not advance |
| intMask | output | 1 | All interrupts masked |
| vecReq | output | 1 | Vector fetch request |
| vecNum | output | VEC_W | Vector number of the fetch |

## Verification
Two collisions matter most. The first is a bus request arriving in the same cycle as a trap, trace or interrupt request. The bench raises these together during program execution and expects the bus release to win, with no vector being loaded. The second is standby falling while reset is still low. The bench expects standby to win, and it also holds reset low while raising standby, which must keep the controller in standby. A behavioural reference model tracks the state every cycle, and every output is compared against it at the falling clock edge.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int NUM_STATES = 6;

  typedef enum logic [2:0] {
    PS_RESET   = 3'd0,
    PS_EXCEPT  = 3'd1,
    PS_EXEC    = 3'd2,
    PS_BUSREL  = 3'd3,
    PS_STOP    = 3'd4,
    PS_STANDBY = 3'd5
  } procState_e;

  typedef enum logic [1:0] {
    VS_RESET,
    VS_TRACE,
    VS_TRAP,
    VS_IRQ
  } vecSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadVec;
    vecSel_e vecSel;
    logic    grantNext;
  } ctlStrobe_t;

endpackage

// File: rtl/pscControl.sv
module pscControl
  import psc_pkg::*;
(
  input  logic       clk,
  input  logic       resetN,
  input  logic       standbyN,
  input  logic       busReq,
  input  logic       irqReq,
  input  logic       traceReq,
  input  logic       trapReq,
  input  logic       sleepDone,
  input  logic       vecDone,
  input  logic       busGrant,
  output procState_e state,
  output ctlStrobe_t strobe
);

  procState_e stateNext;

  always_comb begin
    stateNext      = state;
    strobe.loadVec = (state == PS_RESET);
    strobe.vecSel  = VS_RESET;
    if (!standbyN) begin
      stateNext = PS_STANDBY;
    end else if (state == PS_STANDBY) begin
      if (resetN) stateNext = PS_RESET;
    end else if (!resetN) begin
      stateNext = PS_RESET;
    end else begin
      case (state)
        PS_RESET: stateNext = PS_EXCEPT;
        PS_EXCEPT: if (vecDone) stateNext = PS_EXEC;
        PS_EXEC: begin
          if (busReq) begin
            stateNext = PS_BUSREL;
          end else if (trapReq) begin
            stateNext      = PS_EXCEPT;
            strobe.loadVec = 1'b1;
            strobe.vecSel  = VS_TRAP;
          end else if (traceReq) begin
            stateNext      = PS_EXCEPT;
            strobe.loadVec = 1'b1;
            strobe.vecSel  = VS_TRACE;
          end else if (irqReq) begin
            stateNext      = PS_EXCEPT;
            strobe.loadVec = 1'b1;
            strobe.vecSel  = VS_IRQ;
          end else if (sleepDone) begin
            stateNext = PS_STOP;
          end
        end
        PS_BUSREL: if (!busReq && !busGrant) stateNext = PS_EXEC;
        PS_STOP: begin
          if (irqReq) begin
            stateNext      = PS_EXCEPT;
            strobe.loadVec = 1'b1;
            strobe.vecSel  = VS_IRQ;
          end
        end
        default: stateNext = PS_RESET;
      endcase
    end
    strobe.grantNext = (stateNext == PS_BUSREL) && busReq;
  end

  always_ff @(posedge clk) begin
    state <= stateNext;
  end

  // R2: standby wins from anywhere
  a_r2_standby_entry: assert property (@(posedge clk) disable iff (!resetN && standbyN)
    !standbyN |=> state == PS_STANDBY);

  // R4: reset low outside standby lands in reset
  a_r4_reset_entry: assert property (@(posedge clk) disable iff (!standbyN)
    (!resetN && state != PS_STANDBY) |=> state == PS_RESET);

  // R6: fetch done leaves exception handling
  a_r6_exit_on_done: assert property (@(posedge clk) disable iff (!resetN || !standbyN)
    (state == PS_EXCEPT && vecDone) |=> state == PS_EXEC);

  // R12: nothing else ends exception handling
  a_r12_except_holds: assert property (@(posedge clk) disable iff (!resetN || !standbyN)
    (state == PS_EXCEPT && !vecDone) |=> state == PS_EXCEPT);

endmodule

// File: rtl/pscDatapath.sv
module pscDatapath
  import psc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int VEC_RESET = 0,
  parameter int VEC_TRACE = 5,
  parameter int VEC_TRAP  = 8,
  parameter int VEC_IRQ   = 16
) (
  input  logic             clk,
  input  logic             resetN,
  input  logic             standbyN,
  input  logic             busReq,
  input  ctlStrobe_t       strobe,
  output logic [VEC_W-1:0] vecNum,
  output logic             busGrant
);

  logic [VEC_W-1:0] vecSelected;

  always_comb begin
    case (strobe.vecSel)
      VS_TRACE: vecSelected = VEC_W'(VEC_TRACE);
      VS_TRAP:  vecSelected = VEC_W'(VEC_TRAP);
      VS_IRQ:   vecSelected = VEC_W'(VEC_IRQ);
      default:  vecSelected = VEC_W'(VEC_RESET);
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.loadVec) vecNum <= vecSelected;
    busGrant <= strobe.grantNext;
  end

  // R9: grant drops at the edge that sees the request gone
  a_r9_grant_drop: assert property (@(posedge clk) disable iff (!resetN || !standbyN)
    (busGrant && !busReq) |=> !busGrant);

endmodule

// File: rtl/procStateCtl.sv
module procStateCtl
  import psc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int VEC_RESET = 0,
  parameter int VEC_TRACE = 5,
  parameter int VEC_TRAP  = 8,
  parameter int VEC_IRQ   = 16
) (
  input  logic                  clk,
  input  logic                  resetN,
  input  logic                  standbyN,
  input  logic                  busReq,
  input  logic                  irqReq,
  input  logic                  traceReq,
  input  logic                  trapReq,
  input  logic                  sleepDone,
  input  logic                  vecDone,
  output logic [NUM_STATES-1:0] stateOh,
  output logic                  busGrant,
  output logic                  cpuHalt,
  output logic                  intMask,
  output logic                  vecReq,
  output logic [VEC_W-1:0]      vecNum
);

  procState_e state;
  ctlStrobe_t strobe;

  pscControl uCtl (
    .clk(clk), .resetN(resetN), .standbyN(standbyN), .busReq(busReq),
    .irqReq(irqReq), .traceReq(traceReq), .trapReq(trapReq),
    .sleepDone(sleepDone), .vecDone(vecDone), .busGrant(busGrant),
    .state(state), .strobe(strobe)
  );

  pscDatapath #(
    .VEC_W(VEC_W), .VEC_RESET(VEC_RESET), .VEC_TRACE(VEC_TRACE),
    .VEC_TRAP(VEC_TRAP), .VEC_IRQ(VEC_IRQ)
  ) uDp (
    .clk(clk), .resetN(resetN), .standbyN(standbyN), .busReq(busReq),
    .strobe(strobe), .vecNum(vecNum), .busGrant(busGrant)
  );

  for (genvar i = 0; i < NUM_STATES; i++) begin : gOneHot
    assign stateOh[i] = (state == procState_e'(3'(i)));
  end

  assign cpuHalt = stateOh[PS_RESET] | stateOh[PS_BUSREL] | stateOh[PS_STOP] | stateOh[PS_STANDBY];
  assign intMask = stateOh[PS_RESET] | stateOh[PS_EXCEPT] | stateOh[PS_STANDBY];
  assign vecReq  = stateOh[PS_EXCEPT];

  // R1: exactly one state active
  a_r1_onehot: assert property (@(posedge clk) disable iff (!resetN)
    $countones(stateOh) == 1);

  // R8: grant only while bus released
  a_r8_grant_in_busrel: assert property (@(posedge clk) disable iff (!resetN || !standbyN)
    busGrant |-> stateOh[PS_BUSREL]);

endmodule

// File: tb/procStateCtl_test.sv
`timescale 1ns/1ps
module procStateCtl_test;

  logic clk = 1'b0;
  logic resetN = 1'b0, standbyN = 1'b1;
  logic busReq = 1'b0, irqReq = 1'b0, traceReq = 1'b0, trapReq = 1'b0;
  logic sleepDone = 1'b0, vecDone = 1'b0;
  logic [5:0] stateOh;
  logic busGrant, cpuHalt, intMask, vecReq;
  logic [7:0] vecNum;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;
  string curReq = "R4";

  // reference model: 0 reset,1 except,2 exec,3 busrel,4 stop,5 standby
  int ms = 0, mv = 0;
  bit mg = 0;

  always #2.5 clk = ~clk;

  procStateCtl uut (
    .clk(clk), .resetN(resetN), .standbyN(standbyN), .busReq(busReq),
    .irqReq(irqReq), .traceReq(traceReq), .trapReq(trapReq),
    .sleepDone(sleepDone), .vecDone(vecDone), .stateOh(stateOh),
    .busGrant(busGrant), .cpuHalt(cpuHalt), .intMask(intMask),
    .vecReq(vecReq), .vecNum(vecNum)
  );

  always @(posedge clk) begin
    int ns, nv;
    ns = ms;
    nv = (ms == 0) ? 0 : mv;
    if (!standbyN) ns = 5;
    else if (ms == 5) begin if (resetN) ns = 0; end
    else if (!resetN) ns = 0;
    else begin
      case (ms)
        0: ns = 1;
        1: if (vecDone) ns = 2;
        2: if (busReq) ns = 3;
           else if (trapReq) begin ns = 1; nv = 8; end
           else if (traceReq) begin ns = 1; nv = 5; end
           else if (irqReq) begin ns = 1; nv = 16; end
           else if (sleepDone) ns = 4;
        3: if (!busReq && !mg) ns = 2;
        4: if (irqReq) begin ns = 1; nv = 16; end
        default: ;
      endcase
    end
    mg = (ns == 3) && busReq;
    ms = ns;
    mv = nv;
    started = 1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !finished) begin
    chk($countones(stateOh) == 1, "R1", "onehot count", $countones(stateOh), 1);
    chk(stateOh == 6'(1 << ms), curReq, "stateOh", stateOh, 1 << ms);
    chk(busGrant == mg, curReq, "busGrant", busGrant, mg);
    chk(cpuHalt == (ms == 0 || ms == 3 || ms == 4 || ms == 5), "R11", "cpuHalt", cpuHalt,
        (ms == 0 || ms == 3 || ms == 4 || ms == 5));
    chk(intMask == (ms == 0 || ms == 1 || ms == 5), "R4", "intMask", intMask,
        (ms == 0 || ms == 1 || ms == 5));
    chk(vecReq == (ms == 1), "R6", "vecReq", vecReq, (ms == 1));
    if (ms == 1) chk(vecNum == 8'(mv), curReq, "vecNum", vecNum, mv);
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finishVec();
    vecDone = 1'b1; tick(1); vecDone = 1'b0; tick(1);
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    curReq = "R4"; tick(4);
    curReq = "R5"; resetN = 1'b1; tick(3);
    curReq = "R6"; finishVec();
    // bus release with competing exception sources
    curReq = "R8"; busReq = 1'b1; trapReq = 1'b1; irqReq = 1'b1; tick(1);
    trapReq = 1'b0; irqReq = 1'b0; tick(3);
    curReq = "R9"; busReq = 1'b0; tick(1); busReq = 1'b1; tick(2);
    busReq = 1'b0; tick(3);
    // exception priority
    curReq = "R7"; trapReq = 1'b1; traceReq = 1'b1; irqReq = 1'b1; sleepDone = 1'b1; tick(1);
    trapReq = 1'b0; traceReq = 1'b0; irqReq = 1'b0; sleepDone = 1'b0; tick(1); finishVec();
    traceReq = 1'b1; irqReq = 1'b1; tick(1); traceReq = 1'b0; irqReq = 1'b0; finishVec();
    irqReq = 1'b1; sleepDone = 1'b1; tick(1); irqReq = 1'b0; sleepDone = 1'b0; finishVec();
    // requests during exception handling
    curReq = "R12"; trapReq = 1'b1; tick(1); trapReq = 1'b0;
    busReq = 1'b1; traceReq = 1'b1; irqReq = 1'b1; sleepDone = 1'b1; tick(3);
    busReq = 1'b0; traceReq = 1'b0; irqReq = 1'b0; sleepDone = 1'b0; finishVec();
    // sleep and wake
    curReq = "R10"; sleepDone = 1'b1; tick(1); sleepDone = 1'b0; tick(1);
    trapReq = 1'b1; traceReq = 1'b1; busReq = 1'b1; sleepDone = 1'b1; tick(3);
    trapReq = 1'b0; traceReq = 1'b0; busReq = 1'b0; sleepDone = 1'b0; tick(1);
    irqReq = 1'b1; tick(1); irqReq = 1'b0; finishVec();
    // reset mid-run, then standby over reset
    curReq = "R4"; resetN = 1'b0; tick(2);
    curReq = "R2"; standbyN = 1'b0; tick(3);
    curReq = "R3"; standbyN = 1'b1; tick(3);
    resetN = 1'b1; tick(1); tick(2); finishVec();
    // standby from bus released and exception handling
    curReq = "R2"; busReq = 1'b1; tick(2); standbyN = 1'b0; tick(2);
    busReq = 1'b0; resetN = 1'b0; tick(1);
    curReq = "R3"; resetN = 1'b1; tick(2); standbyN = 1'b1; tick(3);
    curReq = "R2"; standbyN = 1'b0; tick(1); standbyN = 1'b1; tick(3);
    finishVec();
    tick(2);
    summary();
  end

endmodule